// File: doc/BRIEF.md
# Gyro Self-Test Sequencer

This block runs the built-in self-test of a yaw-rate sensor that sits behind a serial master. A one-cycle start pulse launches a fixed four-step sequence over a request/ready transport. The first step is a control write that selects the rate channel with the test excitation applied. The second step reads the rate. The third step is a control write that keeps the rate channel selected with the excitation removed. The fourth step reads the rate again. The serial transport itself is outside the block. Each transaction is offered with a request flag, accepted by a ready flag, and closed by a response strobe, which carries the sample on reads.

When both readings are in, the block subtracts the excitation-off reading from the excitation-on reading. The readings are 14-bit offset binary, with 8192 meaning zero rate, so the offset cancels in the subtraction. The block then judges the signed difference against the expected self-test shift of +6226 LSB for the positive test or −6226 LSB for the negative test. The allowed deviation is a caller-supplied tolerance. A polarity input picks the test. The block reports the result with a one-cycle done strobe, a pass flag and the signed difference.

Top module: `gyro_selftest_seq`

## Requirements
- R1: After reset the block is idle: `done_o`, `pass_o`, `diff_o` and `req_valid_o` are all 0.
- R2: The first transaction of a sequence is a write (`req_write_o`=1). Its control byte is 8'b0010_0010 (0x22) when `polarity_i` was 0 (positive test) and 8'b0010_0001 (0x21) when it was 1 (negative test). Polarity is sampled on the accepted start pulse.
- R3: The transactions run in the order write, read (`req_write_o`=0), write of 8'b0010_0000 (0x20), read: exactly four per sequence.
- R4: A request stays asserted, with stable write flag and data, until `req_ready_i` is seen. A transaction ends only on `rsp_valid_i`, however many cycles that takes.
- R5: `diff_o` equals the first reading minus the second reading, as a 15-bit two's-complement value.
- R6: The expected value is +6226 for the positive test and −6226 for the negative test. `pass_o` requires |difference − expected| ≤ `tol_i`, with the tolerance sampled on the accepted start pulse.
- R7: `pass_o` also requires the sign of the difference to match the polarity: strictly positive for the positive test and strictly negative for the negative test.
- R8: A start pulse that arrives while a sequence is running is ignored: it issues no extra transactions and produces no extra done strobe.
- R9: `done_o` is high for exactly one cycle per sequence. `pass_o` and `diff_o` change only in that cycle and hold until the next one.
- R10: The block is idle again in the cycle `done_o` is high, so a start pulse in that cycle launches a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| polarity_i | input | 1 | 0 = positive test, 1 = negative test |
| tol_i | input | 13 | Allowed deviation from the expected difference, in LSB |
| req_valid_o | output | 1 | Transaction request |
| req_write_o | output | 1 | 1 = control write, 0 = rate read |
| req_data_o | output | 8 | Control byte for writes |
| req_ready_i | input | 1 | Transport accepts the request |
| rsp_valid_i | input | 1 | Transaction complete |
| rsp_data_i | input | 14 | Offset-binary reading on read completion |
| done_o | output | 1 | One-cycle end-of-check strobe |
| pass_o | output | 1 | Check result, held |
| diff_o | output | 15 | Signed on-minus-off difference, held |

## Verification
Two functions can meet in the same cycle: the done strobe of a finished check, and the acceptance of a new start. The bench provokes this by raising the start pulse in exactly the cycle where `done_o` is seen high. It then expects a complete second sequence, with four transactions in order and a second correct result. It also sends start pulses in the middle of a running sequence, and judges that these are dropped by counting transactions and done strobes afterwards.

// File: rtl/gst_pkg.sv
package gst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_WAIT  = 2'd2,
        ST_CHECK = 2'd3
    } gst_state_e;

    // Step numbering: order of the four transactions
    localparam logic [1:0] STEP_EXC_ON  = 2'd0;
    localparam logic [1:0] STEP_RD_ON   = 2'd1;
    localparam logic [1:0] STEP_EXC_OFF = 2'd2;
    localparam logic [1:0] STEP_RD_OFF  = 2'd3;

    // Control bytes: rate channel select with excitation field in the low bits
    localparam logic [7:0] CTRL_RATE_POS = 8'b0010_0010;
    localparam logic [7:0] CTRL_RATE_NEG = 8'b0010_0001;
    localparam logic [7:0] CTRL_RATE_OFF = 8'b0010_0000;

endpackage

// File: rtl/gst_word_sel.sv
module gst_word_sel
    import gst_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic [1:0]    step_i,
    input  logic          neg_i,
    output logic          write_o,
    output logic [CW-1:0] data_o
);

    always_comb begin
        write_o = 1'b0;
        data_o  = '0;
        unique case (step_i)
            STEP_EXC_ON: begin
                write_o = 1'b1;
                data_o  = CW'(neg_i ? CTRL_RATE_NEG : CTRL_RATE_POS);
            end
            STEP_EXC_OFF: begin
                write_o = 1'b1;
                data_o  = CW'(CTRL_RATE_OFF);
            end
            default: begin
                write_o = 1'b0;
                data_o  = '0;
            end
        endcase
    end

endmodule

// File: rtl/gst_judge.sv
module gst_judge #(
    parameter int DW      = 14,
    parameter int TOL_W   = 13,
    parameter int EXP_MAG = 6226
) (
    input  logic [DW-1:0]    on_i,
    input  logic [DW-1:0]    off_i,
    input  logic             neg_i,
    input  logic [TOL_W-1:0] tol_i,
    output logic [DW:0]      diff_o,
    output logic             pass_o
);

    localparam int DIFF_W = DW + 1;
    localparam int ERR_W  = DIFF_W + 1;
    localparam logic signed [ERR_W-1:0] EXP_V = ERR_W'(EXP_MAG);

    logic [DIFF_W-1:0]       diff;
    logic signed [ERR_W-1:0] diff_x;
    logic signed [ERR_W-1:0] err;
    logic [ERR_W-1:0]        mag;
    logic [ERR_W-1:0]        tol_x;
    logic                    sign_ok;

    always_comb begin
        diff    = DIFF_W'(on_i) - DIFF_W'(off_i);
        diff_x  = {diff[DIFF_W-1], diff};
        err     = neg_i ? (diff_x + EXP_V) : (diff_x - EXP_V);
        mag     = err[ERR_W-1] ? ERR_W'(-err) : ERR_W'(err);
        tol_x   = ERR_W'(tol_i);
        sign_ok = neg_i ? diff[DIFF_W-1]
                        : (!diff[DIFF_W-1] && (diff != '0));
        diff_o  = diff;
        pass_o  = sign_ok && (mag <= tol_x);
    end

endmodule

// File: rtl/gyro_selftest_seq.sv
module gyro_selftest_seq
    import gst_pkg::*;
#(
    parameter int DW      = 14,
    parameter int TOL_W   = 13,
    parameter int CW      = 8,
    parameter int EXP_MAG = 6226
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             polarity_i,
    input  logic [TOL_W-1:0] tol_i,
    output logic             req_valid_o,
    output logic             req_write_o,
    output logic [CW-1:0]    req_data_o,
    input  logic             req_ready_i,
    input  logic             rsp_valid_i,
    input  logic [DW-1:0]    rsp_data_i,
    output logic             done_o,
    output logic             pass_o,
    output logic [DW:0]      diff_o
);

    typedef struct packed {
        gst_state_e       st;
        logic [1:0]       step;
        logic             neg;
        logic [TOL_W-1:0] tol;
        logic [DW-1:0]    rd_on;
        logic [DW-1:0]    rd_off;
        logic             done;
        logic             pass;
        logic [DW:0]      diff;
    } regs_t;

    regs_t r_q, r_d;

    logic          j_pass;
    logic [DW:0]   j_diff;

    gst_word_sel #(.CW(CW)) u_word (
        .step_i  (r_q.step),
        .neg_i   (r_q.neg),
        .write_o (req_write_o),
        .data_o  (req_data_o)
    );

    gst_judge #(.DW(DW), .TOL_W(TOL_W), .EXP_MAG(EXP_MAG)) u_judge (
        .on_i   (r_q.rd_on),
        .off_i  (r_q.rd_off),
        .neg_i  (r_q.neg),
        .tol_i  (r_q.tol),
        .diff_o (j_diff),
        .pass_o (j_pass)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_REQ;
                    r_d.step = STEP_EXC_ON;
                    r_d.neg  = polarity_i;
                    r_d.tol  = tol_i;
                end
            end
            ST_REQ: begin
                if (req_ready_i) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid_i) begin
                    if (r_q.step == STEP_RD_ON)  r_d.rd_on  = rsp_data_i;
                    if (r_q.step == STEP_RD_OFF) r_d.rd_off = rsp_data_i;
                    if (r_q.step == STEP_RD_OFF) begin
                        r_d.st = ST_CHECK;
                    end else begin
                        r_d.st   = ST_REQ;
                        r_d.step = r_q.step + 2'd1;
                    end
                end
            end
            ST_CHECK: begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
                r_d.pass = j_pass;
                r_d.diff = j_diff;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_valid_o = (r_q.st == ST_REQ);
    assign done_o      = r_q.done;
    assign pass_o      = r_q.pass;
    assign diff_o      = r_q.diff;

endmodule

// File: rtl/gst_checker.sv
module gst_checker #(
    parameter int DW = 14,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid_o,
    input logic          req_ready_i,
    input logic          req_write_o,
    input logic [CW-1:0] req_data_o,
    input logic          done_o,
    input logic          pass_o,
    input logic [DW:0]   diff_o
);

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=>
            (req_valid_o && $stable(req_data_o) && $stable(req_write_o)));

    p_write_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_write_o) |->
            (req_data_o == CW'(8'h22) || req_data_o == CW'(8'h21) ||
             req_data_o == CW'(8'h20)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(pass_o) && $stable(diff_o)));

    p_pass_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && pass_o) |-> (diff_o != '0));

    p_idle_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !req_valid_o);

endmodule

bind gyro_selftest_seq gst_checker #(.DW(DW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_write_o (req_write_o),
    .req_data_o  (req_data_o),
    .done_o      (done_o),
    .pass_o      (pass_o),
    .diff_o      (diff_o)
);

// File: tb/gyro_selftest_seq_tb.sv
module gyro_selftest_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int EXPV       = 6226;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic        polarity_i;
    logic [12:0] tol_i;
    logic        req_valid_o;
    logic        req_write_o;
    logic [7:0]  req_data_o;
    logic        req_ready_i;
    logic        rsp_valid_i;
    logic [13:0] rsp_data_i;
    logic        done_o;
    logic        pass_o;
    logic [14:0] diff_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int g_base = 8192;
    int g_delta = 0;
    int g_lat = 0;
    int op_cnt = 0;
    bit excited = 0;
    bit         op_wr [0:7];
    logic [7:0] op_word [0:7];

    always #(CLK_PERIOD/2) clk = ~clk;

    gyro_selftest_seq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .polarity_i  (polarity_i),
        .tol_i       (tol_i),
        .req_valid_o (req_valid_o),
        .req_write_o (req_write_o),
        .req_data_o  (req_data_o),
        .req_ready_i (req_ready_i),
        .rsp_valid_i (rsp_valid_i),
        .rsp_data_i  (rsp_data_i),
        .done_o      (done_o),
        .pass_o      (pass_o),
        .diff_o      (diff_o)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Transport model: optional ready hold-off, then response after g_lat cycles
    initial begin
        req_ready_i = 1'b0;
        rsp_valid_i = 1'b0;
        rsp_data_i  = '0;
        forever begin
            @(negedge clk);
            if (req_valid_o) begin
                repeat (g_lat) @(negedge clk);
                req_ready_i = 1'b1;
                if (op_cnt < 8) begin
                    op_wr[op_cnt]   = req_write_o;
                    op_word[op_cnt] = req_data_o;
                end
                op_cnt++;
                if (req_write_o) excited = (req_data_o != 8'h20);
                rsp_data_i = req_write_o ? 14'd0
                           : 14'(excited ? (g_base + g_delta) : g_base);
                @(negedge clk);
                req_ready_i = 1'b0;
                repeat (g_lat) @(negedge clk);
                rsp_valid_i = 1'b1;
                @(negedge clk);
                rsp_valid_i = 1'b0;
            end
        end
    end

    task automatic check_result(input bit pol, input int tol, input int delta);
        int  e;
        bit  exp_pass;
        e = delta - (pol ? -EXPV : EXPV);
        if (e < 0) e = -e;
        exp_pass = (e <= tol) && (pol ? (delta < 0) : (delta > 0));
        chk(int'($signed(diff_o)) == delta, "R5 diff", int'($signed(diff_o)), delta);
        chk(pass_o == exp_pass, pol ? "R6/R7 pass neg" : "R6/R7 pass pos",
            int'(pass_o), int'(exp_pass));
        chk(op_cnt == 4, "R3 transaction count", op_cnt, 4);
        chk(op_wr[0] == 1'b1 && op_word[0] == (pol ? 8'h21 : 8'h22),
            "R2 first write code", int'(op_word[0]), pol ? 33 : 34);
        chk(op_wr[1] == 1'b0 && op_wr[2] == 1'b1 && op_wr[3] == 1'b0,
            "R3 order", {op_wr[0], op_wr[1], op_wr[2], op_wr[3]}, 10);
        chk(op_word[2] == 8'h20, "R3 off write code", int'(op_word[2]), 32);
    endtask

    task automatic wait_done(input bit poke, output bit seen);
        int n = 0;
        while (!done_o && n < 400) begin
            if (poke && (n == 3 || n == 9)) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            n++;
        end
        seen = done_o;
        chk(seen, "R9 done seen", int'(seen), 1);
    endtask

    task automatic run(input bit pol, input int tol, input int base, input int delta,
                       input int lat, input bit poke, input bit chain);
        bit seen;
        g_base = base; g_delta = delta; g_lat = lat; op_cnt = 0;
        polarity_i = pol; tol_i = 13'(tol); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; polarity_i = !pol; tol_i = '0;  // sampled at start only
        wait_done(poke, seen);
        if (!seen) return;
        check_result(pol, tol, delta);
        if (chain) begin
            // R10: start raised in the done cycle
            op_cnt = 0; polarity_i = pol; tol_i = 13'(tol); start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0; polarity_i = !pol; tol_i = '0;
            chk(!done_o, "R9 done one cycle (chain)", int'(done_o), 0);
            wait_done(1'b0, seen);
            if (!seen) return;
            chk(1'b1, "R10 second sequence completed", 1, 1);
            check_result(pol, tol, delta);
        end
        @(negedge clk);
        chk(!done_o, "R9 done one cycle", int'(done_o), 0);
        if (poke) begin
            repeat (20) @(negedge clk);
            chk(op_cnt == 4, "R8 extra start ignored", op_cnt, 4);
            chk(!req_valid_o && !done_o, "R8 idle after ignored start",
                int'(req_valid_o) + int'(done_o), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int tols [3] = '{0, 5, 100};
        int bases [2] = '{8192, 8000};
        rst_n = 1'b0; start_i = 1'b0; polarity_i = 1'b0; tol_i = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done_o && !pass_o && diff_o == '0 && !req_valid_o, "R1 reset idle",
            int'(done_o) + int'(pass_o) + int'(diff_o) + int'(req_valid_o), 0);

        // Sweep around the pass/fail edges, both polarities
        for (int p = 0; p < 2; p++) begin
            for (int ti = 0; ti < 3; ti++) begin
                for (int bi = 0; bi < 2; bi++) begin
                    int ex;
                    int t;
                    int offs [5];
                    ex = (p == 1) ? -EXPV : EXPV;
                    t  = tols[ti];
                    offs = '{-t - 1, -t, 0, t, t + 1};
                    for (int k = 0; k < 5; k++)
                        run(p[0], t, bases[bi], ex + offs[k], (k + ti) % 3, 1'b0, 1'b0);
                    run(p[0], t, bases[bi], -ex, 1, 1'b0, 1'b0);
                    run(p[0], t, bases[bi], 0, 0, 1'b0, 1'b0);
                end
            end
        end

        // R7: sign mismatch inside a wide tolerance
        run(1'b0, 8191, 8192, -100, 0, 1'b0, 1'b0);
        run(1'b0, 8191, 8192, 0, 1, 1'b0, 1'b0);
        run(1'b1, 8191, 8192, 100, 2, 1'b0, 1'b0);
        run(1'b1, 8191, 8192, -1, 0, 1'b0, 1'b0);
        // R5: extreme readings
        run(1'b0, 8191, 0, 16383, 1, 1'b0, 1'b0);
        run(1'b1, 8191, 16383, -16383, 0, 1'b0, 1'b0);
        // R4: long ready hold-off and response latency
        run(1'b0, 10, 8192, 6230, 6, 1'b0, 1'b0);
        // R8: start pulses in mid-sequence
        run(1'b1, 10, 8192, -6220, 2, 1'b1, 1'b0);
        run(1'b0, 10, 8192, 6226, 0, 1'b1, 1'b0);
        // R10: start in the done cycle
        run(1'b0, 20, 8192, 6210, 1, 1'b0, 1'b1);
        run(1'b1, 3, 8100, -6230, 0, 1'b0, 1'b1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule